// File: doc/BRIEF.md
# Isochronous OUT Endpoint Receive Controller

This block is the receive-side control for four OUT endpoints in a device-side serial bus function. A simple packet interface in front of it delivers an OUT token with its endpoint index, then a data byte per strobe, then an end-of-packet strobe with a CRC-good flag. Each endpoint has a one-packet buffer of up to 64 bytes. For each packet the block decides whether to store it, sets sticky error flags, raises the endpoint's receive interrupt and drives one shared error interrupt.

Endpoint indices 0 to 3 on the token interface stand for endpoints 1 to 4. A CPU register port gives access to the mode bit, the max-packet limit, the error flags, the buffer status, the data fetch port and the packet release. Each endpoint with its mode bit set follows isochronous rules. No handshake is returned and no data toggle is checked. A packet with a bad CRC is still kept. A token that finds unread data is an overrun. A packet longer than the limit is discarded.

Register address (6 bits): bit 5 = 0 selects an endpoint register, with bits 4:3 the endpoint index and bits 2:0 the selector. Selectors: 0 mode (bit 0), 1 flags, 2 max packet, 3 status, 4 data, 5 release. Bit 5 = 1 selects the global registers: selector 0 is the error interrupt enable (bit 0) and selector 1 is the read-only summary (bit 0).

Top module: `iso_out_rx`

## Requirements
- R1: After reset every mode bit, flag, error enable and buffer is clear, every max-packet register reads 0x40, and epIrq and errIrq are low.
- R2: A token for an endpoint with mode bit 1 and an empty buffer, followed by N bytes and end-of-packet, stores the packet. From the cycle after end-of-packet the status register (selector 3) reads bit 7 = 1 and bits 6:0 = N, and epIrq for that endpoint is high.
- R3: A packet that ends with the CRC-good input low is still stored, and flag bit 0 (data error) of the flags register (selector 1) is set.
- R4: A token that arrives while the endpoint still holds an unread packet sets flag bit 1 (overrun). Its bytes are dropped, and the stored packet, its count and its data stay as they were.
- R5: A packet with more bytes than the endpoint's max-packet value is not stored: the status register stays 0 and flag bit 2 (force stall) is set.
- R6: A write of a value above 64 to the max-packet register (selector 2) reads back as 64. A packet of exactly the max-packet length is accepted, and so is a zero-length packet, with count 0.
- R7: Flags are sticky. Writing 1 to a flag bit clears that bit only, writing 0 leaves it set, and a new event in the same cycle wins over a clear.
- R8: errIrq is high exactly when the error enable is 1 and some flag of some endpoint is set. The summary register (global selector 1) bit 0 reads the same value.
- R9: When an endpoint's mode bit is 0, its tokens and packets change no buffer, flag or interrupt.
- R10: Each read of the data register (selector 4) returns the next stored byte in arrival order. A write to the release register (selector 5) empties the buffer, drops epIrq and resets the read position for the next packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tokValid | input | 1 | OUT token strobe |
| tokEp | input | 2 | Endpoint index of the token (0..3 for endpoints 1..4) |
| dataValid | input | 1 | Data byte strobe |
| dataByte | input | 8 | Received data byte |
| eopValid | input | 1 | End-of-packet strobe |
| crcOk | input | 1 | CRC-good flag, sampled with eopValid |
| regWr | input | 1 | CPU register write strobe |
| regRd | input | 1 | CPU register read strobe (advances the data port) |
| regAddr | input | 6 | CPU register address |
| regWdata | input | 8 | CPU write data |
| regRdata | output | 8 | CPU read data, combinational from regAddr |
| epIrq | output | 4 | Per-endpoint receive interrupt, high while a packet is unread |
| errIrq | output | 1 | Shared error interrupt |

## Verification
The assertions check, on every cycle, that no byte is written into a buffer that holds an unread packet, that a packet is committed only into an empty buffer, and that stored counts never exceed 64. They also check that a flag only falls after a write of 1 to that bit, that an overrun flag only rises after a token for that endpoint, and that a receive interrupt only rises after an end-of-packet strobe. Only the bench scenarios can show which data and flags follow from a given packet: the oversize discard, kept data after an overrun, ignoring a disabled endpoint, the clamp of the limit, enable gating of the error interrupt and the reset of the read position by release.

// File: rtl/iso_rx_pkg.sv
package iso_rx_pkg;
  localparam int EP_COUNT  = 4;
  localparam int BUF_BYTES = 64;
  localparam int EP_W      = (EP_COUNT > 1) ? $clog2(EP_COUNT) : 1;
  localparam int IDX_W     = $clog2(BUF_BYTES);
  localparam int CNT_W     = $clog2(BUF_BYTES + 1);
  localparam int SEL_W     = 3;
  localparam int ADDR_W    = 1 + EP_W + SEL_W;
  localparam int FLAG_W    = 3;

  // per-endpoint selectors
  localparam logic [SEL_W-1:0] SEL_MODE  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd1;
  localparam logic [SEL_W-1:0] SEL_MAXP  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_STAT  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_REL   = 3'd5;
  // global selectors
  localparam logic [SEL_W-1:0] SEL_ERREN = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SUM   = 3'd1;

  // flag bit positions
  localparam int FLG_DERR  = 0;
  localparam int FLG_OVR   = 1;
  localparam int FLG_STALL = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_CAPT, RX_DROP} rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wr;
    logic [EP_W-1:0]   wrEp;
    logic [IDX_W-1:0]  wrIdx;
    logic [7:0]        wrData;
    logic              commit;
    logic [CNT_W-1:0]  commitCnt;
    logic              rel;
    logic              pop;
    logic [EP_W-1:0]   cpuEp;
  } dpCtl_t;
endpackage

// File: rtl/iso_rx_dp.sv
module iso_rx_dp
  import iso_rx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  dpCtl_t                          ctl,
  output logic [EP_COUNT-1:0]             bufValid,
  output logic [EP_COUNT-1:0][CNT_W-1:0]  bufCount,
  output logic [7:0]                      rdByte
);
  logic [7:0] mem [EP_COUNT][BUF_BYTES];
  logic [EP_COUNT-1:0][IDX_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    if (ctl.wr) mem[ctl.wrEp][ctl.wrIdx] <= ctl.wrData;
  end

  for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
    logic hitCommit, hitRel, hitPop;
    assign hitCommit = ctl.commit && (ctl.wrEp == EP_W'(e));
    assign hitRel    = ctl.rel && (ctl.cpuEp == EP_W'(e));
    assign hitPop    = ctl.pop && (ctl.cpuEp == EP_W'(e));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufValid[e] <= 1'b0;
        bufCount[e] <= '0;
        rdPtr[e]    <= '0;
      end else if (hitCommit) begin
        bufValid[e] <= 1'b1;
        bufCount[e] <= ctl.commitCnt;
        rdPtr[e]    <= '0;
      end else if (hitRel) begin
        bufValid[e] <= 1'b0;
        bufCount[e] <= '0;
        rdPtr[e]    <= '0;
      end else if (hitPop && bufValid[e] &&
                   (int'(rdPtr[e]) + 1 < int'(bufCount[e]))) begin
        rdPtr[e] <= rdPtr[e] + IDX_W'(1);
      end
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      int'(bufCount[e]) <= BUF_BYTES) else $error("count above buffer size"); // R6
  end

  assign rdByte = mem[ctl.cpuEp][rdPtr[ctl.cpuEp]];

  AST_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wr |-> !bufValid[ctl.wrEp]) else $error("byte written into unread buffer"); // R4
  AST_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |-> !bufValid[ctl.wrEp]) else $error("commit into occupied buffer"); // R2
endmodule

// File: rtl/iso_rx_ctrl.sv
module iso_rx_ctrl
  import iso_rx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            tokValid,
  input  logic [EP_W-1:0]                 tokEp,
  input  logic                            dataValid,
  input  logic [7:0]                      dataByte,
  input  logic                            eopValid,
  input  logic                            crcOk,
  input  logic                            regWr,
  input  logic                            regRd,
  input  logic [ADDR_W-1:0]               regAddr,
  input  logic [7:0]                      regWdata,
  output logic [7:0]                      regRdata,
  input  logic [EP_COUNT-1:0]             bufValid,
  input  logic [EP_COUNT-1:0][CNT_W-1:0]  bufCount,
  input  logic [7:0]                      rdByte,
  output dpCtl_t                          ctl,
  output logic                            errIrq
);
  rxState_t state, stNext;
  logic [EP_W-1:0]  curEp, epNext;
  logic [CNT_W-1:0] wrCount, cntNext;
  logic             tooBig, bigNext;

  logic [EP_COUNT-1:0]             modeBits;
  logic [EP_COUNT-1:0][FLAG_W-1:0] errFlags;
  logic [EP_COUNT-1:0][CNT_W-1:0]  maxPkt;
  logic                            errEn;

  logic [EP_COUNT-1:0] setOvr, setStall, setDerr;

  logic             isGlob;
  logic [EP_W-1:0]  aEp;
  logic [SEL_W-1:0] aSel;
  logic             epWr;

  assign isGlob = regAddr[ADDR_W-1];
  assign aEp    = regAddr[SEL_W +: EP_W];
  assign aSel   = regAddr[SEL_W-1:0];
  assign epWr   = regWr && !isGlob;

  // packet acceptance
  always_comb begin
    ctl           = '0;
    ctl.cpuEp     = aEp;
    ctl.wrEp      = curEp;
    ctl.wrIdx     = wrCount[IDX_W-1:0];
    ctl.wrData    = dataByte;
    ctl.commitCnt = wrCount;
    ctl.pop       = regRd && !isGlob && (aSel == SEL_DATA);
    ctl.rel       = epWr && (aSel == SEL_REL);
    stNext   = state;
    epNext   = curEp;
    cntNext  = wrCount;
    bigNext  = tooBig;
    setOvr   = '0;
    setStall = '0;
    setDerr  = '0;
    if (tokValid) begin
      epNext  = tokEp;
      cntNext = '0;
      bigNext = 1'b0;
      if (!modeBits[tokEp]) begin
        stNext = RX_IDLE;
      end else if (bufValid[tokEp]) begin
        stNext        = RX_DROP;
        setOvr[tokEp] = 1'b1;
      end else begin
        stNext = RX_CAPT;
      end
    end else if (state == RX_CAPT) begin
      if (dataValid) begin
        if (wrCount < maxPkt[curEp]) begin
          ctl.wr  = 1'b1;
          cntNext = wrCount + CNT_W'(1);
        end else begin
          bigNext = 1'b1;
        end
      end
      if (eopValid) begin
        stNext = RX_IDLE;
        if (tooBig) begin
          setStall[curEp] = 1'b1;
        end else begin
          ctl.commit     = 1'b1;
          setDerr[curEp] = !crcOk;
        end
      end
    end else if (state == RX_DROP && eopValid) begin
      stNext = RX_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= RX_IDLE;
      curEp   <= '0;
      wrCount <= '0;
      tooBig  <= 1'b0;
      errEn   <= 1'b0;
    end else begin
      state   <= stNext;
      curEp   <= epNext;
      wrCount <= cntNext;
      tooBig  <= bigNext;
      if (regWr && isGlob && aSel == SEL_ERREN) errEn <= regWdata[0];
    end
  end

  // per-endpoint configuration and sticky flags
  for (genvar e = 0; e < EP_COUNT; e++) begin : g_ep
    logic             hitEp;
    logic [FLAG_W-1:0] clrMask, setMask;
    assign hitEp   = epWr && (aEp == EP_W'(e));
    assign clrMask = (hitEp && aSel == SEL_FLAGS) ? regWdata[FLAG_W-1:0] : '0;
    assign setMask = {setStall[e], setOvr[e], setDerr[e]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        modeBits[e] <= 1'b0;
        errFlags[e] <= '0;
        maxPkt[e]   <= CNT_W'(BUF_BYTES);
      end else begin
        errFlags[e] <= (errFlags[e] & ~clrMask) | setMask;
        if (hitEp && aSel == SEL_MODE) modeBits[e] <= regWdata[0];
        if (hitEp && aSel == SEL_MAXP) begin
          if (regWdata > 8'(BUF_BYTES)) maxPkt[e] <= CNT_W'(BUF_BYTES);
          else                          maxPkt[e] <= regWdata[CNT_W-1:0];
        end
      end
    end

    for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
        $fell(errFlags[e][b]) |-> $past(epWr && aEp == EP_W'(e) && aSel == SEL_FLAGS && regWdata[b]))
        else $error("flag cleared without write of one"); // R7
    end

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(errFlags[e][FLG_OVR]) |-> $past(tokValid && tokEp == EP_W'(e)))
      else $error("overrun without token"); // R4
  end

  assign errIrq = errEn && (|errFlags);

  // register read mux
  always_comb begin
    regRdata = '0;
    if (isGlob) begin
      case (aSel)
        SEL_ERREN: regRdata = {7'd0, errEn};
        SEL_SUM:   regRdata = {7'd0, errIrq};
        default:   regRdata = '0;
      endcase
    end else begin
      case (aSel)
        SEL_MODE:  regRdata = {7'd0, modeBits[aEp]};
        SEL_FLAGS: regRdata = 8'(errFlags[aEp]);
        SEL_MAXP:  regRdata = 8'(maxPkt[aEp]);
        SEL_STAT:  regRdata = {bufValid[aEp], 7'(bufCount[aEp])};
        SEL_DATA:  regRdata = rdByte;
        default:   regRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/iso_out_rx.sv
module iso_out_rx
  import iso_rx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tokValid,
  input  logic [EP_W-1:0]      tokEp,
  input  logic                 dataValid,
  input  logic [7:0]           dataByte,
  input  logic                 eopValid,
  input  logic                 crcOk,
  input  logic                 regWr,
  input  logic                 regRd,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [7:0]           regWdata,
  output logic [7:0]           regRdata,
  output logic [EP_COUNT-1:0]  epIrq,
  output logic                 errIrq
);
  dpCtl_t                         ctl;
  logic [EP_COUNT-1:0]            bufValid;
  logic [EP_COUNT-1:0][CNT_W-1:0] bufCount;
  logic [7:0]                     rdByte;

  iso_rx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .tokValid(tokValid), .tokEp(tokEp),
    .dataValid(dataValid), .dataByte(dataByte),
    .eopValid(eopValid), .crcOk(crcOk),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .bufValid(bufValid), .bufCount(bufCount), .rdByte(rdByte),
    .ctl(ctl), .errIrq(errIrq)
  );

  iso_rx_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .bufValid(bufValid), .bufCount(bufCount), .rdByte(rdByte)
  );

  assign epIrq = bufValid;

  for (genvar e = 0; e < EP_COUNT; e++) begin : g_chk
    AST_RXIRQ_AT_EOP: assert property (@(posedge clk) disable iff (!rstN)
      $rose(epIrq[e]) |-> $past(eopValid)) else $error("receive irq without end of packet"); // R2
  end
endmodule

// File: tb/sim_iso_out_rx.sv
module sim_iso_out_rx;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tokValid = 1'b0;
  logic [1:0] tokEp = '0;
  logic       dataValid = 1'b0;
  logic [7:0] dataByte = '0;
  logic       eopValid = 1'b0;
  logic       crcOk = 1'b1;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [5:0] regAddr = '0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [3:0] epIrq;
  logic       errIrq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_out_rx u0 (
    .clk(clk), .rstN(rstN), .tokValid(tokValid), .tokEp(tokEp),
    .dataValid(dataValid), .dataByte(dataByte), .eopValid(eopValid), .crcOk(crcOk),
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .epIrq(epIrq), .errIrq(errIrq)
  );

  typedef struct packed {
    logic [1:0] ep;
    logic [6:0] len;
    logic       crc;
    logic [7:0] expStat;
    logic [2:0] expFlg;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{ep:2'd0, len:7'd4,  crc:1'b1, expStat:8'h84, expFlg:3'd0},  // R2
    '{ep:2'd1, len:7'd8,  crc:1'b1, expStat:8'h88, expFlg:3'd0},  // R6 exact limit
    '{ep:2'd1, len:7'd9,  crc:1'b1, expStat:8'h00, expFlg:3'd4},  // R5
    '{ep:2'd2, len:7'd3,  crc:1'b0, expStat:8'h83, expFlg:3'd1},  // R3
    '{ep:2'd3, len:7'd5,  crc:1'b1, expStat:8'h00, expFlg:3'd0},  // R9
    '{ep:2'd0, len:7'd0,  crc:1'b1, expStat:8'h80, expFlg:3'd0},  // R6 zero length
    '{ep:2'd2, len:7'd64, crc:1'b1, expStat:8'hC0, expFlg:3'd0}   // R6 full buffer
  };

  function automatic logic [5:0] epA(input logic [1:0] ep, input logic [2:0] sel);
    return {1'b0, ep, sel};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic cpuRead(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic sendPkt(input logic [1:0] ep, input int len, input logic [7:0] base, input logic crc);
    @(negedge clk);
    tokValid = 1'b1; tokEp = ep;
    @(negedge clk);
    tokValid = 1'b0;
    for (int i = 0; i < len; i++) begin
      dataValid = 1'b1; dataByte = 8'(base + i);
      @(negedge clk);
    end
    dataValid = 1'b0; eopValid = 1'b1; crcOk = crc;
    @(negedge clk);
    eopValid = 1'b0; crcOk = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int e = 0; e < 4; e++) begin
      cpuRead(epA(2'(e), 3'd0), rd); check("R1 mode", rd, 8'h00);
      cpuRead(epA(2'(e), 3'd1), rd); check("R1 flags", rd, 8'h00);
      cpuRead(epA(2'(e), 3'd2), rd); check("R1 maxp", rd, 8'h40);
      cpuRead(epA(2'(e), 3'd3), rd); check("R1 status", rd, 8'h00);
    end
    cpuRead(6'h20, rd); check("R1 erren", rd, 8'h00);
    check("R1 epIrq", 8'(epIrq), 8'h00);
    check("R1 errIrq", 8'(errIrq), 8'h00);

    // setup: endpoints 0..2 isochronous, endpoint 3 left off
    for (int e = 0; e < 3; e++) cpuWrite(epA(2'(e), 3'd0), 8'h01);
    cpuWrite(epA(2'd1, 3'd2), 8'd8);
    cpuWrite(epA(2'd2, 3'd2), 8'd100);
    cpuRead(epA(2'd2, 3'd2), rd); check("R6 clamp", rd, 8'h40);

    // table walk
    for (int k = 0; k < NV; k++) begin
      vec_t v;
      v = VECS[k];
      sendPkt(v.ep, int'(v.len), 8'(k * 16), v.crc);
      check($sformatf("R2 irq vec%0d", k), 8'(epIrq[v.ep]), 8'(v.expStat[7]));
      cpuRead(epA(v.ep, 3'd3), rd); check($sformatf("R2 status vec%0d", k), rd, v.expStat);
      cpuRead(epA(v.ep, 3'd1), rd); check($sformatf("R3 R5 flags vec%0d", k), rd, 8'(v.expFlg));
      check($sformatf("R8 errIrq off vec%0d", k), 8'(errIrq), 8'h00);
      if (v.expStat[7]) begin
        for (int i = 0; i < int'(v.len); i++) begin
          cpuRead(epA(v.ep, 3'd4), rd);
          check($sformatf("R10 data vec%0d", k), rd, 8'(k * 16 + i));
        end
        cpuWrite(epA(v.ep, 3'd5), 8'h00);
        cpuRead(epA(v.ep, 3'd3), rd); check("R10 release status", rd, 8'h00);
        check("R10 release irq", 8'(epIrq[v.ep]), 8'h00);
      end
      cpuWrite(epA(v.ep, 3'd1), 8'h07);
    end

    // R4 overrun keeps stored packet
    sendPkt(2'd0, 2, 8'hA0, 1'b1);
    sendPkt(2'd0, 3, 8'h50, 1'b1);
    cpuRead(epA(2'd0, 3'd3), rd); check("R4 status kept", rd, 8'h82);
    cpuRead(epA(2'd0, 3'd1), rd); check("R4 overrun flag", rd, 8'h02);
    check("R8 gated off", 8'(errIrq), 8'h00);
    cpuWrite(6'h20, 8'h01);
    check("R8 errIrq on", 8'(errIrq), 8'h01);
    cpuRead(6'h21, rd); check("R8 summary", rd, 8'h01);
    cpuWrite(epA(2'd0, 3'd1), 8'h05);
    cpuRead(epA(2'd0, 3'd1), rd); check("R7 sticky", rd, 8'h02);
    cpuRead(epA(2'd0, 3'd4), rd); check("R4 data kept 0", rd, 8'hA0);
    cpuRead(epA(2'd0, 3'd4), rd); check("R4 data kept 1", rd, 8'hA1);
    cpuWrite(epA(2'd0, 3'd1), 8'h02);
    cpuRead(epA(2'd0, 3'd1), rd); check("R7 clear", rd, 8'h00);
    check("R8 errIrq drop", 8'(errIrq), 8'h00);
    cpuWrite(epA(2'd0, 3'd5), 8'h00);

    // R3 with enable set: bad CRC raises error irq, data kept
    sendPkt(2'd2, 1, 8'h77, 1'b0);
    check("R3 errIrq", 8'(errIrq), 8'h01);
    cpuRead(epA(2'd2, 3'd4), rd); check("R3 data kept", rd, 8'h77);
    cpuWrite(epA(2'd2, 3'd1), 8'h01);
    cpuWrite(epA(2'd2, 3'd5), 8'h00);

    // R10 release resets the read position
    sendPkt(2'd0, 3, 8'h10, 1'b1);
    cpuRead(epA(2'd0, 3'd4), rd); check("R10 first", rd, 8'h10);
    cpuWrite(epA(2'd0, 3'd5), 8'h00);
    sendPkt(2'd0, 2, 8'h30, 1'b1);
    cpuRead(epA(2'd0, 3'd4), rd); check("R10 restart", rd, 8'h30);

    // R9 mode cleared: token on a full endpoint is ignored
    cpuWrite(epA(2'd0, 3'd0), 8'h00);
    sendPkt(2'd0, 2, 8'h90, 1'b0);
    cpuRead(epA(2'd0, 3'd1), rd); check("R9 no flag", rd, 8'h00);
    cpuRead(epA(2'd0, 3'd3), rd); check("R9 status kept", rd, 8'h82);
    check("R9 no errIrq", 8'(errIrq), 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule